// File: doc/BRIEF.md
# Ping-Pong Endpoint Packet Buffer

This block holds the packet data of one bulk or interrupt data endpoint of a full-speed USB device. It has two banks of `DEPTH` bytes (64 by default). A byte-wide CPU port fills or empties one bank while the USB packet engine moves the other bank on the bus, so the CPU side and the bus side overlap. Ownership of each bank passes between the two sides, and the banks are taken strictly in turn. Each side keeps its own one-bit bank pointer, which moves only when that side hands a bank over.

The parameter `DIR` selects the endpoint direction. For an IN endpoint the CPU writes bytes and then commits the bank with its byte count, and the USB engine reads the bytes out. For an OUT endpoint the USB engine writes a received packet and the CPU reads it. Whenever the USB engine has nothing valid to move (no committed bank for IN, no empty bank for OUT), `usb_nak` tells it to answer the token with a NAK handshake. The parameter `NB` set to 1 gives a single-bank variant. Packet encoding and CRC belong to the USB engine and are not handled here.

Top module: `pp_ep_buf`

## Requirements
- R1: After reset every bank is empty. An IN buffer shows `usb_nak`=1 and `cpu_ok`=1. An OUT buffer shows `usb_nak`=0 and `cpu_ok`=0. `cpu_irq` and `buf_ovf` are 0.
- R2: IN: bytes written with `cpu_wr` fill the CPU bank from index 0 upward. A one-cycle `cpu_commit` then hands the bank to the USB side with byte count `cpu_count`. After that `usb_nak`=0, `usb_len` equals the count, and each `usb_rd` pulse steps `usb_rdata` to the next byte in the order written.
- R3: IN: `usb_nak` is 1 while no bank is committed. When every bank is committed, `cpu_ok`=0, and `cpu_wr` and `cpu_commit` have no effect.
- R4: IN: a `usb_done` pulse on a committed bank frees it and sets `cpu_irq`. A `cpu_irq_clr` pulse (write-1-to-clear) clears the flag. Committed banks are sent in the order they were committed.
- R5: A `usb_abort` pulse rewinds the USB byte index to 0 and leaves bank ownership unchanged. An IN bank is then read again from its first byte. An OUT packet is received again from index 0.
- R6: IN: committing with count 0 gives `usb_nak`=0 and `usb_len`=0 (a zero-length packet).
- R7: OUT: bytes written with `usb_wr` fill the USB bank from index 0. `usb_done` marks that bank full with the number of bytes written. This sets `cpu_irq`=1 and `cpu_ok`=1 and shows the count on `cpu_len`. Each `cpu_rd` pulse steps `cpu_rdata` through the bytes in order.
- R8: OUT: when every bank is full, `usb_nak`=1, and `usb_wr` and `usb_done` have no effect.
- R9: OUT: a `cpu_irq_clr` pulse frees the CPU bank and moves the CPU side to the next bank. `cpu_irq` stays 1 if that bank is also full, and its count and data then appear.
- R10: A write beyond `DEPTH` bytes into one bank, from either side, is dropped and sets `buf_ovf`. The flag stays set until reset, and the bytes already stored are unchanged.
- R11: With `NB`=1 a single bank alternates between the sides. After an IN commit, `cpu_ok`=0 until `usb_done` frees the bank.
- R12: IN: a `cpu_count` above `DEPTH` is stored as `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU byte write strobe (IN) |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rd | input | 1 | CPU byte read advance (OUT) |
| cpu_rdata | output | 8 | Byte at the CPU index of the CPU bank |
| cpu_commit | input | 1 | Hand the CPU bank to the USB side (IN) |
| cpu_count | input | CW | Byte count given with a commit |
| cpu_irq_clr | input | 1 | Write-1 strobe clearing the interrupt flag; releases the bank for OUT |
| cpu_ok | output | 1 | CPU bank is usable (free for IN, holding a packet for OUT) |
| cpu_len | output | CW | Byte count of the CPU bank |
| cpu_irq | output | 1 | Interrupt flag |
| buf_ovf | output | 1 | Sticky overflow flag |
| usb_wr | input | 1 | USB byte write strobe (OUT) |
| usb_wdata | input | 8 | USB write byte |
| usb_rd | input | 1 | USB byte read advance (IN) |
| usb_rdata | output | 8 | Byte at the USB index of the USB bank |
| usb_done | input | 1 | Transfer finished successfully |
| usb_abort | input | 1 | Transfer failed; retry the same bank |
| usb_nak | output | 1 | Answer the token with NAK |
| usb_len | output | CW | Byte count of the USB bank |

## Verification
The bench builds three copies: an IN endpoint with two banks, an OUT endpoint with two banks, and an IN endpoint with `NB`=1. All use the default 64-byte depth. The two-bank copies reach the state where both banks are held by one side, where the NAK and ignored-strobe rules apply, and the strict alternation of banks. The single-bank copy reaches the case where one bank serves both sides in turn. The 64-byte depth makes the overflow boundary reachable with 65 writes and a count clamp with a commit of 100.

// File: rtl/pp_ep_pkg.sv
package pp_ep_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] ep_byte_t;

    typedef enum logic {
        EP_OUT = 1'b0,
        EP_IN  = 1'b1
    } ep_dir_e;

    // Next bank for one side: alternates with two banks, stays at 0 with one.
    function automatic logic next_bank(input logic cur, input int unsigned banks);
        return (banks > 1) ? ~cur : 1'b0;
    endfunction

endpackage

// File: rtl/ep_byte_ptr.sv
module ep_byte_ptr #(
    parameter  int DEPTH = 64,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    output logic [CW-1:0] ptr,
    output logic          at_end
);

    assign at_end = (ptr == CW'(DEPTH));

    // Saturating byte index: 0..DEPTH
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr <= '0;
        end else if (step && !at_end) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/ep_bank_ram.sv
module ep_bank_ram
    import pp_ep_pkg::*;
#(
    parameter  int DEPTH = 64,
    parameter  int NB    = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int IW    = (NB > 1) ? AW + 1 : AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic          w_bank,
    input  logic [AW-1:0] w_addr,
    input  ep_byte_t      w_data,
    input  logic          a_bank,
    input  logic [AW-1:0] a_addr,
    output ep_byte_t      a_data,
    input  logic          b_bank,
    input  logic [AW-1:0] b_addr,
    output ep_byte_t      b_data
);

    ep_byte_t mem [0:(2**IW)-1];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[IW'({w_bank, w_addr})] <= w_data;
        end
    end

    assign a_data = mem[IW'({a_bank, a_addr})];
    assign b_data = mem[IW'({b_bank, b_addr})];

endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl
    import pp_ep_pkg::*;
#(
    parameter  int      DEPTH = 64,
    parameter  int      NB    = 2,
    parameter  ep_dir_e DIR   = EP_IN,
    localparam int      CW    = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_take,
    input  logic [CW-1:0]       cpu_count,
    input  logic                usb_take,
    input  logic [CW-1:0]       usb_count,
    output logic                cpu_sel,
    output logic                usb_sel,
    output logic [1:0]          full,
    output logic [1:0][CW-1:0]  len
);

    localparam logic IS_IN = (DIR == EP_IN);

    logic [CW-1:0] cpu_cnt_c;
    assign cpu_cnt_c = (cpu_count > CW'(DEPTH)) ? CW'(DEPTH) : cpu_count;

    // Each side owns one pointer and moves it only on its own hand-over
    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_sel <= 1'b0;
            usb_sel <= 1'b0;
        end else begin
            if (cpu_take) cpu_sel <= next_bank(cpu_sel, NB);
            if (usb_take) usb_sel <= next_bank(usb_sel, NB);
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        if (b < NB) begin : g_live
            logic          f_q;
            logic [CW-1:0] l_q;
            // A bank cannot be valid for both sides at once, so at most one branch applies
            always_ff @(posedge clk) begin
                if (rst) begin
                    f_q <= 1'b0;
                    l_q <= '0;
                end else if (cpu_take && cpu_sel == 1'(b)) begin
                    f_q <= IS_IN;
                    if (IS_IN) l_q <= cpu_cnt_c;
                end else if (usb_take && usb_sel == 1'(b)) begin
                    f_q <= !IS_IN;
                    if (!IS_IN) l_q <= usb_count;
                end
            end
            assign full[b] = f_q;
            assign len[b]  = l_q;
        end else begin : g_absent
            assign full[b] = 1'b0;
            assign len[b]  = '0;
        end
    end

endmodule

// File: rtl/pp_ep_buf.sv
module pp_ep_buf
    import pp_ep_pkg::*;
#(
    parameter  ep_dir_e DIR   = EP_IN,
    parameter  int      NB    = 2,
    parameter  int      DEPTH = 64,
    localparam int      CW    = $clog2(DEPTH + 1),
    localparam int      AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_wr,
    input  logic [7:0]    cpu_wdata,
    input  logic          cpu_rd,
    output logic [7:0]    cpu_rdata,
    input  logic          cpu_commit,
    input  logic [CW-1:0] cpu_count,
    input  logic          cpu_irq_clr,
    output logic          cpu_ok,
    output logic [CW-1:0] cpu_len,
    output logic          cpu_irq,
    output logic          buf_ovf,
    input  logic          usb_wr,
    input  logic [7:0]    usb_wdata,
    input  logic          usb_rd,
    output logic [7:0]    usb_rdata,
    input  logic          usb_done,
    input  logic          usb_abort,
    output logic          usb_nak,
    output logic [CW-1:0] usb_len
);

    localparam logic IS_IN = (DIR == EP_IN);

    logic               cpu_sel, usb_sel;
    logic [1:0]         full_q;
    logic [1:0][CW-1:0] len_q;
    logic [CW-1:0]      cpu_ptr, usb_ptr;
    logic               cpu_end, usb_end;
    logic               cpu_own, usb_own;
    logic               cpu_take, usb_take;
    logic               cpu_wr_go, usb_wr_go;
    logic               cpu_step, usb_step;
    logic               ram_we, ram_wbank;
    logic [AW-1:0]      ram_waddr;
    ep_byte_t           ram_wdata, cpu_rd_byte, usb_rd_byte;
    logic               ovf_q;

    // Which side may touch its current bank
    assign cpu_own = IS_IN ? !full_q[cpu_sel] : full_q[cpu_sel];
    assign usb_own = IS_IN ?  full_q[usb_sel] : !full_q[usb_sel];

    assign cpu_take  = cpu_own && (IS_IN ? cpu_commit : cpu_irq_clr);
    assign usb_take  = usb_own && usb_done;

    assign cpu_wr_go = IS_IN  && cpu_own && cpu_wr;
    assign usb_wr_go = !IS_IN && usb_own && usb_wr;
    assign cpu_step  = cpu_wr_go || (!IS_IN && cpu_own && cpu_rd);
    assign usb_step  = usb_wr_go || (IS_IN && usb_own && usb_rd);

    ep_bank_ctrl #(.DEPTH(DEPTH), .NB(NB), .DIR(DIR)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_take  (cpu_take),
        .cpu_count (cpu_count),
        .usb_take  (usb_take),
        .usb_count (usb_ptr),
        .cpu_sel   (cpu_sel),
        .usb_sel   (usb_sel),
        .full      (full_q),
        .len       (len_q)
    );

    ep_byte_ptr #(.DEPTH(DEPTH)) u_cpu_ptr (
        .clk    (clk),
        .rst    (rst),
        .clr    (cpu_take),
        .step   (cpu_step),
        .ptr    (cpu_ptr),
        .at_end (cpu_end)
    );

    ep_byte_ptr #(.DEPTH(DEPTH)) u_usb_ptr (
        .clk    (clk),
        .rst    (rst),
        .clr    (usb_take || usb_abort),
        .step   (usb_step),
        .ptr    (usb_ptr),
        .at_end (usb_end)
    );

    // The writer is fixed by direction: CPU for IN, USB for OUT
    assign ram_we    = IS_IN ? (cpu_wr_go && !cpu_end) : (usb_wr_go && !usb_end);
    assign ram_wbank = IS_IN ? cpu_sel   : usb_sel;
    assign ram_waddr = IS_IN ? cpu_ptr[AW-1:0] : usb_ptr[AW-1:0];
    assign ram_wdata = IS_IN ? cpu_wdata : usb_wdata;

    ep_bank_ram #(.DEPTH(DEPTH), .NB(NB)) u_ram (
        .clk    (clk),
        .we     (ram_we),
        .w_bank (ram_wbank),
        .w_addr (ram_waddr),
        .w_data (ram_wdata),
        .a_bank (cpu_sel),
        .a_addr (cpu_ptr[AW-1:0]),
        .a_data (cpu_rd_byte),
        .b_bank (usb_sel),
        .b_addr (usb_ptr[AW-1:0]),
        .b_data (usb_rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if ((cpu_wr_go && cpu_end) || (usb_wr_go && usb_end)) begin
            ovf_q <= 1'b1;
        end
    end

    if (IS_IN) begin : g_in_irq
        logic irq_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                irq_q <= 1'b0;
            end else if (usb_take) begin
                irq_q <= 1'b1;
            end else if (cpu_irq_clr) begin
                irq_q <= 1'b0;
            end
        end
        assign cpu_irq = irq_q;
    end else begin : g_out_irq
        assign cpu_irq = full_q[cpu_sel];
    end

    assign cpu_ok    = cpu_own;
    assign cpu_len   = len_q[cpu_sel];
    assign usb_len   = len_q[usb_sel];
    assign usb_nak   = !usb_own;
    assign buf_ovf   = ovf_q;
    assign cpu_rdata = cpu_end ? '0 : cpu_rd_byte;
    assign usb_rdata = usb_end ? '0 : usb_rd_byte;

endmodule

// File: rtl/pp_ep_buf_chk.sv
module pp_ep_buf_chk
    import pp_ep_pkg::*;
#(
    parameter  ep_dir_e DIR   = EP_IN,
    parameter  int      NB    = 2,
    parameter  int      DEPTH = 64,
    localparam int      CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          usb_done,
    input logic          usb_abort,
    input logic          usb_nak,
    input logic [CW-1:0] usb_len,
    input logic          cpu_irq,
    input logic          buf_ovf,
    input logic [1:0]    full_q,
    input logic          usb_sel
);

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        buf_ovf |=> buf_ovf);

    assert_abort_keeps_bank_R5: assert property (@(posedge clk) disable iff (rst)
        (usb_abort && !usb_done) |=> $stable(usb_sel));

    assert_len_in_range_R12: assert property (@(posedge clk) disable iff (rst)
        usb_len <= CW'(DEPTH));

    if (DIR == EP_IN) begin : g_in
        assert_irq_after_send_R4: assert property (@(posedge clk) disable iff (rst)
            (usb_done && !usb_nak) |=> cpu_irq);
        assert_nak_when_empty_R3: assert property (@(posedge clk) disable iff (rst)
            (full_q == 2'b00) |-> usb_nak);
    end else begin : g_out
        assert_irq_after_rx_R7: assert property (@(posedge clk) disable iff (rst)
            (usb_done && !usb_nak) |=> cpu_irq);
        if (NB > 1) begin : g_two
            assert_nak_all_full_R8: assert property (@(posedge clk) disable iff (rst)
                (&full_q) |-> usb_nak);
        end
    end

endmodule

bind pp_ep_buf pp_ep_buf_chk #(.DIR(DIR), .NB(NB), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .usb_done  (usb_done),
    .usb_abort (usb_abort),
    .usb_nak   (usb_nak),
    .usb_len   (usb_len),
    .cpu_irq   (cpu_irq),
    .buf_ovf   (buf_ovf),
    .full_q    (full_q),
    .usb_sel   (usb_sel)
);

// File: tb/test_pp_ep_buf.sv
module test_pp_ep_buf;
    import pp_ep_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks = 0;
    int   fails  = 0;

    always #10 clk = ~clk;

    // A: IN, two banks
    logic a_cpu_wr = 0, a_cpu_rd = 0, a_cpu_commit = 0, a_cpu_irq_clr = 0;
    logic a_usb_wr = 0, a_usb_rd = 0, a_usb_done = 0, a_usb_abort = 0;
    logic [7:0] a_cpu_wdata = 0, a_usb_wdata = 0, a_cpu_rdata, a_usb_rdata;
    logic [6:0] a_cpu_count = 0, a_cpu_len, a_usb_len;
    logic a_cpu_ok, a_cpu_irq, a_buf_ovf, a_usb_nak;

    // B: OUT, two banks
    logic b_cpu_wr = 0, b_cpu_rd = 0, b_cpu_commit = 0, b_cpu_irq_clr = 0;
    logic b_usb_wr = 0, b_usb_rd = 0, b_usb_done = 0, b_usb_abort = 0;
    logic [7:0] b_cpu_wdata = 0, b_usb_wdata = 0, b_cpu_rdata, b_usb_rdata;
    logic [6:0] b_cpu_count = 0, b_cpu_len, b_usb_len;
    logic b_cpu_ok, b_cpu_irq, b_buf_ovf, b_usb_nak;

    // C: IN, single bank
    logic c_cpu_wr = 0, c_cpu_rd = 0, c_cpu_commit = 0, c_cpu_irq_clr = 0;
    logic c_usb_wr = 0, c_usb_rd = 0, c_usb_done = 0, c_usb_abort = 0;
    logic [7:0] c_cpu_wdata = 0, c_usb_wdata = 0, c_cpu_rdata, c_usb_rdata;
    logic [6:0] c_cpu_count = 0, c_cpu_len, c_usb_len;
    logic c_cpu_ok, c_cpu_irq, c_buf_ovf, c_usb_nak;

    pp_ep_buf #(.DIR(EP_IN), .NB(2)) i_pp_ep_buf (
        .clk(clk), .rst(rst),
        .cpu_wr(a_cpu_wr), .cpu_wdata(a_cpu_wdata), .cpu_rd(a_cpu_rd), .cpu_rdata(a_cpu_rdata),
        .cpu_commit(a_cpu_commit), .cpu_count(a_cpu_count), .cpu_irq_clr(a_cpu_irq_clr),
        .cpu_ok(a_cpu_ok), .cpu_len(a_cpu_len), .cpu_irq(a_cpu_irq), .buf_ovf(a_buf_ovf),
        .usb_wr(a_usb_wr), .usb_wdata(a_usb_wdata), .usb_rd(a_usb_rd), .usb_rdata(a_usb_rdata),
        .usb_done(a_usb_done), .usb_abort(a_usb_abort), .usb_nak(a_usb_nak), .usb_len(a_usb_len)
    );

    pp_ep_buf #(.DIR(EP_OUT), .NB(2)) i_pp_ep_buf_out (
        .clk(clk), .rst(rst),
        .cpu_wr(b_cpu_wr), .cpu_wdata(b_cpu_wdata), .cpu_rd(b_cpu_rd), .cpu_rdata(b_cpu_rdata),
        .cpu_commit(b_cpu_commit), .cpu_count(b_cpu_count), .cpu_irq_clr(b_cpu_irq_clr),
        .cpu_ok(b_cpu_ok), .cpu_len(b_cpu_len), .cpu_irq(b_cpu_irq), .buf_ovf(b_buf_ovf),
        .usb_wr(b_usb_wr), .usb_wdata(b_usb_wdata), .usb_rd(b_usb_rd), .usb_rdata(b_usb_rdata),
        .usb_done(b_usb_done), .usb_abort(b_usb_abort), .usb_nak(b_usb_nak), .usb_len(b_usb_len)
    );

    pp_ep_buf #(.DIR(EP_IN), .NB(1)) i_pp_ep_buf_single (
        .clk(clk), .rst(rst),
        .cpu_wr(c_cpu_wr), .cpu_wdata(c_cpu_wdata), .cpu_rd(c_cpu_rd), .cpu_rdata(c_cpu_rdata),
        .cpu_commit(c_cpu_commit), .cpu_count(c_cpu_count), .cpu_irq_clr(c_cpu_irq_clr),
        .cpu_ok(c_cpu_ok), .cpu_len(c_cpu_len), .cpu_irq(c_cpu_irq), .buf_ovf(c_buf_ovf),
        .usb_wr(c_usb_wr), .usb_wdata(c_usb_wdata), .usb_rd(c_usb_rd), .usb_rdata(c_usb_rdata),
        .usb_done(c_usb_done), .usb_abort(c_usb_abort), .usb_nak(c_usb_nak), .usb_len(c_usb_len)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- IN, two banks ----------------
    task automatic a_write(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            a_cpu_wr = 1'b1; a_cpu_wdata = 8'(base + i);
            @(negedge clk);
        end
        a_cpu_wr = 1'b0;
    endtask

    task automatic a_commit(input int cnt);
        a_cpu_commit = 1'b1; a_cpu_count = 7'(cnt);
        @(negedge clk);
        a_cpu_commit = 1'b0;
    endtask

    task automatic a_done();
        a_usb_done = 1'b1; @(negedge clk); a_usb_done = 1'b0;
    endtask

    task automatic a_clr();
        a_cpu_irq_clr = 1'b1; @(negedge clk); a_cpu_irq_clr = 1'b0;
    endtask

    task automatic a_read(input int n, input int base, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, "usb byte", a_usb_rdata, (base + i) & 255);
            a_usb_rd = 1'b1;
            @(negedge clk);
        end
        a_usb_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "IN usb_nak", a_usb_nak, 1);
        chk("R1", "IN cpu_ok", a_cpu_ok, 1);
        chk("R1", "IN cpu_irq", a_cpu_irq, 0);
        chk("R1", "IN buf_ovf", a_buf_ovf, 0);
        chk("R1", "OUT usb_nak", b_usb_nak, 0);
        chk("R1", "OUT cpu_ok", b_cpu_ok, 0);
        chk("R1", "OUT cpu_irq", b_cpu_irq, 0);
        chk("R1", "single usb_nak", c_usb_nak, 1);
    endtask

    task automatic t_in_basic();
        a_write(5, 8'h10);
        chk("R3", "nak before commit", a_usb_nak, 1);
        a_commit(5);
        chk("R2", "nak after commit", a_usb_nak, 0);
        chk("R2", "usb_len", a_usb_len, 5);
        a_read(5, 8'h10, "R2");
        a_done();
        chk("R4", "irq after send", a_cpu_irq, 1);
        chk("R3", "nak after send", a_usb_nak, 1);
        a_clr();
        chk("R4", "irq cleared", a_cpu_irq, 0);
    endtask

    task automatic t_in_pingpong();
        a_write(3, 8'hA0); a_commit(3);
        a_write(2, 8'hB0); a_commit(2);
        chk("R3", "cpu_ok both committed", a_cpu_ok, 0);
        a_write(1, 8'hEE);
        a_commit(9);
        chk("R3", "usb_len unchanged", a_usb_len, 3);
        a_read(3, 8'hA0, "R4");
        a_done();
        chk("R4", "second bank len", a_usb_len, 2);
        chk("R4", "second bank ready", a_usb_nak, 0);
        a_read(2, 8'hB0, "R3");
        a_done();
        chk("R4", "nak after both sent", a_usb_nak, 1);
        a_clr();
    endtask

    task automatic t_in_abort();
        a_write(4, 8'hC0); a_commit(4);
        a_read(2, 8'hC0, "R5");
        a_usb_abort = 1'b1; @(negedge clk); a_usb_abort = 1'b0;
        chk("R5", "nak after abort", a_usb_nak, 0);
        chk("R5", "len after abort", a_usb_len, 4);
        chk("R5", "irq after abort", a_cpu_irq, 0);
        a_read(4, 8'hC0, "R5");
        a_done(); a_clr();
    endtask

    task automatic t_in_zlp();
        a_commit(0);
        chk("R6", "zlp nak", a_usb_nak, 0);
        chk("R6", "zlp len", a_usb_len, 0);
        a_done();
        chk("R6", "zlp sent", a_usb_nak, 1);
        a_clr();
    endtask

    task automatic t_in_overflow();
        a_write(64, 0);
        chk("R10", "no ovf at 64", a_buf_ovf, 0);
        a_write(1, 8'hFF);
        chk("R10", "ovf set", a_buf_ovf, 1);
        a_commit(100);
        chk("R12", "clamped len", a_usb_len, 64);
        a_read(64, 0, "R10");
        a_done(); a_clr();
        chk("R10", "ovf sticky", a_buf_ovf, 1);
    endtask

    // ---------------- OUT, two banks ----------------
    task automatic b_write(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            b_usb_wr = 1'b1; b_usb_wdata = 8'(base + i);
            @(negedge clk);
        end
        b_usb_wr = 1'b0;
    endtask

    task automatic b_done();
        b_usb_done = 1'b1; @(negedge clk); b_usb_done = 1'b0;
    endtask

    task automatic b_release();
        b_cpu_irq_clr = 1'b1; @(negedge clk); b_cpu_irq_clr = 1'b0;
    endtask

    task automatic b_read(input int n, input int base, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, "cpu byte", b_cpu_rdata, (base + i) & 255);
            b_cpu_rd = 1'b1;
            @(negedge clk);
        end
        b_cpu_rd = 1'b0;
    endtask

    task automatic t_out_basic();
        b_write(6, 8'h20);
        chk("R7", "irq before done", b_cpu_irq, 0);
        b_done();
        chk("R7", "irq after rx", b_cpu_irq, 1);
        chk("R7", "cpu_ok after rx", b_cpu_ok, 1);
        chk("R7", "cpu_len", b_cpu_len, 6);
        b_read(6, 8'h20, "R7");
    endtask

    task automatic t_out_full();
        b_write(2, 8'h50);
        b_done();
        chk("R8", "nak both full", b_usb_nak, 1);
        b_write(1, 8'h99);
        b_done();
        b_release();
        chk("R9", "irq stays", b_cpu_irq, 1);
        chk("R9", "second len", b_cpu_len, 2);
        chk("R9", "nak released", b_usb_nak, 0);
        b_read(2, 8'h50, "R8");
        b_release();
        chk("R9", "irq clear", b_cpu_irq, 0);
        chk("R9", "cpu_ok clear", b_cpu_ok, 0);
    endtask

    task automatic t_out_abort();
        b_write(3, 8'h60);
        b_usb_abort = 1'b1; @(negedge clk); b_usb_abort = 1'b0;
        chk("R5", "OUT no irq after abort", b_cpu_irq, 0);
        b_write(1, 8'h77);
        b_done();
        chk("R5", "OUT len after retry", b_cpu_len, 1);
        b_read(1, 8'h77, "R5");
        b_release();
    endtask

    // ---------------- IN, single bank ----------------
    task automatic t_single();
        chk("R11", "cpu_ok at start", c_cpu_ok, 1);
        c_cpu_wr = 1'b1; c_cpu_wdata = 8'h3C; @(negedge clk); c_cpu_wr = 1'b0;
        c_cpu_commit = 1'b1; c_cpu_count = 7'd1; @(negedge clk); c_cpu_commit = 1'b0;
        chk("R11", "cpu_ok after commit", c_cpu_ok, 0);
        chk("R11", "nak after commit", c_usb_nak, 0);
        c_cpu_commit = 1'b1; c_cpu_count = 7'd5; @(negedge clk); c_cpu_commit = 1'b0;
        chk("R11", "second commit ignored", c_usb_len, 1);
        chk("R11", "usb byte", c_usb_rdata, 8'h3C);
        c_usb_done = 1'b1; @(negedge clk); c_usb_done = 1'b0;
        chk("R11", "cpu_ok after send", c_cpu_ok, 1);
        chk("R11", "nak after send", c_usb_nak, 1);
        chk("R11", "irq after send", c_cpu_irq, 1);
        c_cpu_commit = 1'b1; c_cpu_count = 7'd2; @(negedge clk); c_cpu_commit = 1'b0;
        chk("R11", "bank reused len", c_usb_len, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_in_basic();
        t_in_pingpong();
        t_in_abort();
        t_in_zlp();
        t_in_overflow();
        t_out_basic();
        t_out_full();
        t_out_abort();
        t_single();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule